// File: doc/BRIEF.md
# Serial Key Word Readout Port

This block lets a host controller read a held 24-bit key word over three wires: an active-low select, a shift clock and one data output. The scanner hands the block a debounced key word with a one-cycle strobe. The block keeps that word and raises a pending request. While the host leaves the block deselected, the data line shows that request. When the host selects the block, the same line carries a framed word. The frame is one leading dummy bit, the 24 key bits with the first key first, and a trailing dummy bit. The line moves to the next bit on each falling shift clock, so the host samples on rising edges.

Both pad inputs are synchronised into the system clock domain, and all edge detection happens there. The block tells the scanner when it may capture a new word. It also reports, with one-cycle pulses, whether each selected session ended as a complete read or an early abort. Either way the held word is dropped and the request is cleared, so the scanner is re-armed.

Top module: `key_link_readout`

## Requirements
- R1: After reset the data line is low, the capture-allowed output is high, and neither the done pulse nor the abort pulse is asserted.
- R2: A capture strobe is accepted only while the block is deselected and no request is pending. An accepted strobe stores the key word and sets the request, which shows as a high data line while deselected.
- R3: A capture strobe while a request is pending, or while selected, is ignored. The held word and the request keep their values.
- R4: While selected, the frame position starts at the leading dummy (driven low). Each falling shift clock advances it to key bits KD1..KD24, where KDn is bit n-1 of the captured word. Then comes the trailing dummy (low), and any later falling edges keep the line low.
- R5: If the shift clock is high when the select falls, the first falling edge moves the line to KD1 before any rising edge. If the clock is low, the host's first rising edge samples the leading dummy.
- R6: The data line changes only after a falling shift clock edge while the block stays selected.
- R7: Deselecting after at least one falling edge beyond KD24 ends a complete read. It gives a one-cycle done pulse and clears the request.
- R8: Deselecting earlier gives a one-cycle abort pulse, clears the request and discards the held word. The done and abort pulses are never asserted together.
- R9: A read with no request pending shifts out zeros for every position.
- R10: The capture-allowed output is high exactly when the block is deselected and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Host select pin, active low, asynchronous |
| host_sclk | input | 1 | Host shift clock pin, asynchronous |
| host_sdo | output | 1 | Data line: request flag when deselected, frame bits when selected |
| cap_strobe | input | 1 | Scanner strobe offering a new key word |
| cap_word | input | 24 | Key word; bit n-1 is KDn |
| scan_ok | output | 1 | Scanner may capture (deselected, no request pending) |
| read_done | output | 1 | One-cycle pulse: session ended after a complete read |
| read_abort | output | 1 | One-cycle pulse: session ended early |

## Verification
On every cycle, the assertions check four things. The line holds still between falling edges while selected. Nothing past the trailing dummy is ever driven high. The held word does not change while a request is pending. A done pulse is followed by a cleared request and never coincides with an abort. Only the bench's scenarios can show the bit order of a whole frame under both select-time clock levels. They also show that an aborted word is really gone on the next read, and that strobes arriving while selected or pending leave no trace at the pins.

// File: rtl/key_link_pkg.sv
// Package: shared sizes for the serial key readout port.
// Assumes a rectangular key matrix and one dummy bit on each side of the word.
package key_link_pkg;
    localparam int KEY_ROWS = 4;
    localparam int KEY_COLS = 6;
    localparam int KEY_BITS = KEY_ROWS * KEY_COLS;
    // Frame positions: 0 lead dummy, 1..KEY_BITS data, KEY_BITS+1 trailing dummy.
    localparam int FRAME_END = KEY_BITS + 1;
    localparam int POS_W = $clog2(FRAME_END + 1);

    // Session outcome reported to the scanner.
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_DONE  = 2'd1,
        END_ABORT = 2'd2
    } end_kind_t;
endpackage

// File: rtl/key_link_sync.sv
// Module: multi-bit two-stage synchroniser for asynchronous pad inputs.
// Assumes each bit is independent (no bus coherency needed); RST_VAL gives
// each bit's idle level so that reset does not create a false edge.
module key_link_sync #(
    parameter int WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stable_q;
            // Two flops per bit to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= RST_VAL[b];
                    stable_q <= RST_VAL[b];
                end else begin
                    meta_q   <= async_in[b];
                    stable_q <= meta_q;
                end
            end
            assign sync_out[b] = stable_q;
        end
    endgenerate
endmodule

// File: rtl/key_link_hold.sv
// Module: holds the captured key word and the request flag, and classifies
// the end of each selected session as a complete read or an abort.
// Assumes sel_n_s is already synchronised and that read_full comes from the
// framer's position before that position is cleared by deselection.
module key_link_hold
    import key_link_pkg::*;
#(
    parameter int BITS = KEY_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n_s,
    input  logic            read_full,
    input  logic            cap_strobe,
    input  logic [BITS-1:0] cap_word,
    output logic            req,
    output logic [BITS-1:0] held,
    output logic            scan_ok,
    output logic            read_done,
    output logic            read_abort
);
    logic      sel_n_prev;
    logic      sel_rise;
    logic      take;
    end_kind_t outcome;

    // Remember the previous select level to find the end of a session.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_n_prev <= 1'b1;
        else        sel_n_prev <= sel_n_s;
    end

    assign sel_rise = sel_n_s && !sel_n_prev;
    assign scan_ok  = sel_n_s && !req;
    assign take     = cap_strobe && scan_ok;

    // Decide how the session that just ended should be reported.
    always_comb begin
        outcome = END_NONE;
        if (sel_rise) outcome = read_full ? END_DONE : END_ABORT;
    end

    // Request flag: set by an accepted capture, cleared by any session end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 req <= 1'b0;
        else if (outcome != END_NONE) req <= 1'b0;
        else if (take)              req <= 1'b1;
    end

    // Key word storage: loaded on capture, dropped when a session ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                 held <= '0;
        else if (outcome != END_NONE) held <= '0;
        else if (take)              held <= cap_word;
    end

    // One-cycle outcome pulses towards the scanner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_done  <= 1'b0;
            read_abort <= 1'b0;
        end else begin
            read_done  <= (outcome == END_DONE);
            read_abort <= (outcome == END_ABORT);
        end
    end
endmodule

// File: rtl/key_link_framer.sv
// Module: frame position counter and data line multiplexer.
// Assumes synchronised select and shift clock; the position is held at the
// leading dummy while deselected and saturates at the trailing dummy.
module key_link_framer
    import key_link_pkg::*;
#(
    parameter int BITS = KEY_BITS,
    parameter int PW   = POS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n_s,
    input  logic            sclk_s,
    input  logic            req,
    input  logic [BITS-1:0] held,
    output logic            sclk_fall,
    output logic [PW-1:0]   pos,
    output logic            read_full,
    output logic            sdo
);
    localparam logic [PW-1:0] LAST = PW'(BITS + 1);
    localparam logic [PW-1:0] ONE  = PW'(1);
    localparam logic [PW-1:0] TOP  = PW'(BITS);

    logic            sclk_prev;
    logic [PW-1:0]   idx;
    logic [BITS-1:0] shifted;
    logic            in_data;
    logic            frame_bit;

    // Previous shift clock level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_fall = sclk_prev && !sclk_s;

    // Advance one frame position per falling shift clock while selected.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n_s)            pos <= '0;
        else if (sclk_fall && pos != LAST) pos <= pos + ONE;
    end

    assign read_full = (pos == LAST);

    // Pick the key bit for the current position; dummies and no-request read as zero.
    always_comb begin
        in_data   = (pos >= ONE) && (pos <= TOP);
        idx       = in_data ? (pos - ONE) : '0;
        shifted   = held >> idx;
        frame_bit = in_data && req && shifted[0];
    end

    // Data line: request flag while deselected, frame bit while selected.
    assign sdo = sel_n_s ? req : frame_bit;
endmodule

// File: rtl/key_link_readout.sv
// Module: top of the serial key readout port.
// Assumes host pins are asynchronous to clk and slow enough (several clk
// cycles per shift clock phase) for synchronised edge detection.
module key_link_readout
    import key_link_pkg::*;
#(
    parameter int BITS = KEY_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_sel_n,
    input  logic            host_sclk,
    output logic            host_sdo,
    input  logic            cap_strobe,
    input  logic [BITS-1:0] cap_word,
    output logic            scan_ok,
    output logic            read_done,
    output logic            read_abort
);
    localparam int PW = $clog2(BITS + 2);

    logic [1:0]      pins_s;
    logic            sel_n_s;
    logic            sclk_s;
    logic            req;
    logic [BITS-1:0] held;
    logic            sclk_fall;
    logic [PW-1:0]   pos;
    logic            read_full;

    key_link_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_sclk, host_sel_n}),
        .sync_out (pins_s)
    );

    assign sel_n_s = pins_s[0];
    assign sclk_s  = pins_s[1];

    key_link_hold #(.BITS(BITS)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_s    (sel_n_s),
        .read_full  (read_full),
        .cap_strobe (cap_strobe),
        .cap_word   (cap_word),
        .req        (req),
        .held       (held),
        .scan_ok    (scan_ok),
        .read_done  (read_done),
        .read_abort (read_abort)
    );

    key_link_framer #(.BITS(BITS), .PW(PW)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (sel_n_s),
        .sclk_s    (sclk_s),
        .req       (req),
        .held      (held),
        .sclk_fall (sclk_fall),
        .pos       (pos),
        .read_full (read_full),
        .sdo       (host_sdo)
    );
endmodule

// File: rtl/key_link_readout_chk.sv
// Module: assertion checker bound to the readout port top.
module key_link_readout_chk #(
    parameter int BITS = 24,
    parameter int PW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sel_n_s,
    input logic            sclk_fall,
    input logic            sdo,
    input logic            req,
    input logic [BITS-1:0] held,
    input logic [PW-1:0]   pos,
    input logic            read_done,
    input logic            read_abort
);
    // R6: line is stable between falling edges during a selected session.
    a_r6_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_s && $past(!sel_n_s) && !$past(sclk_fall)) |-> $stable(sdo));

    // R4: after the last key bit the line stays low.
    a_r4_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_s && pos > PW'(BITS)) |-> !sdo);

    // R3: the held word does not move while a request stays pending.
    a_r3_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> $stable(held));

    // R7: a done pulse follows a cleared request.
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |-> !req);

    // R8: the two outcome pulses never overlap.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_done && read_abort));
endmodule

bind key_link_readout key_link_readout_chk #(.BITS(BITS), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n_s    (sel_n_s),
    .sclk_fall  (sclk_fall),
    .sdo        (host_sdo),
    .req        (req),
    .held       (held),
    .pos        (pos),
    .read_done  (read_done),
    .read_abort (read_abort)
);

// File: tb/key_link_readout_tb.sv
// Directed bench for the serial key readout port.
module key_link_readout_tb_top;
    localparam int BITS = 24;
    localparam int HALF = 6;   // system cycles per host pin phase

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_sel_n = 1'b1;
    logic            host_sclk = 1'b0;
    logic            host_sdo;
    logic            cap_strobe = 1'b0;
    logic [BITS-1:0] cap_word = '0;
    logic            scan_ok;
    logic            read_done;
    logic            read_abort;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int abort_cnt = 0;
    bit finished = 1'b0;
    logic got [0:31];

    always #10 clk = ~clk;

    key_link_readout dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_sclk(host_sclk),
        .host_sdo(host_sdo), .cap_strobe(cap_strobe), .cap_word(cap_word),
        .scan_ok(scan_ok), .read_done(read_done), .read_abort(read_abort)
    );

    // Count outcome pulses seen at the ports.
    always @(posedge clk) begin
        if (read_done)  done_cnt++;
        if (read_abort) abort_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic capture(input logic [BITS-1:0] w);
        @(negedge clk);
        cap_word = w;
        cap_strobe = 1'b1;
        @(negedge clk);
        cap_strobe = 1'b0;
        wait_cyc(HALF);
    endtask

    // Host read: select with the given idle clock level, run n rising edges
    // (sampling before each), then deselect.
    task automatic host_read(input bit idle_high, input int n);
        host_sclk = idle_high;
        wait_cyc(HALF);
        host_sel_n = 1'b0;
        wait_cyc(HALF);
        if (idle_high) begin
            chk("R5 lead dummy before first fall", 32'(host_sdo), 0);
            host_sclk = 1'b0;
            wait_cyc(HALF);
        end
        for (int i = 0; i < n; i++) begin
            got[i] = host_sdo;
            host_sclk = 1'b1;
            wait_cyc(HALF);
            host_sclk = 1'b0;
            wait_cyc(HALF);
        end
        host_sel_n = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic t_reset;
        chk("R1 sdo after reset", 32'(host_sdo), 0);
        chk("R1 scan_ok after reset", 32'(scan_ok), 1);
        chk("R1 no done pulse", 32'(done_cnt), 0);
        chk("R1 no abort pulse", 32'(abort_cnt), 0);
    endtask

    task automatic t_read_clock_high(input logic [BITS-1:0] w);
        int d0 = done_cnt;
        int errs = 0;
        capture(w);
        chk("R2 request on line", 32'(host_sdo), 1);
        chk("R10 scan_ok low when pending", 32'(scan_ok), 0);
        host_read(1'b1, 28);
        for (int i = 0; i < BITS; i++) if (got[i] !== w[i]) errs++;
        chk("R4 R5 key bits clock-high start", 32'(errs), 0);
        chk("R4 trailing dummy low", 32'({got[24], got[25], got[26], got[27]}), 0);
        chk("R7 done pulse", 32'(done_cnt - d0), 1);
        chk("R7 request cleared", 32'(host_sdo), 0);
        chk("R10 scan_ok back", 32'(scan_ok), 1);
    endtask

    task automatic t_read_clock_low(input logic [BITS-1:0] w);
        int d0 = done_cnt;
        int errs = 0;
        capture(w);
        host_read(1'b0, 27);
        chk("R5 lead dummy sampled", 32'(got[0]), 0);
        for (int i = 0; i < BITS; i++) if (got[i+1] !== w[i]) errs++;
        chk("R4 key bits clock-low start", 32'(errs), 0);
        chk("R4 trailing low", 32'({got[25], got[26]}), 0);
        chk("R7 done pulse clock-low", 32'(done_cnt - d0), 1);
    endtask

    task automatic t_abort(input logic [BITS-1:0] w);
        int a0 = abort_cnt;
        int d0 = done_cnt;
        int ones = 0;
        capture(w);
        host_read(1'b1, 10);
        chk("R8 abort pulse", 32'(abort_cnt - a0), 1);
        chk("R8 no done on abort", 32'(done_cnt - d0), 0);
        chk("R8 request cleared", 32'(host_sdo), 0);
        host_read(1'b1, 26);
        for (int i = 0; i < 26; i++) if (got[i] !== 1'b0) ones++;
        chk("R9 R8 discarded word reads zero", 32'(ones), 0);
    endtask

    task automatic t_ignored(input logic [BITS-1:0] keep, input logic [BITS-1:0] other);
        int errs = 0;
        capture(keep);
        capture(other);
        host_read(1'b1, 26);
        for (int i = 0; i < BITS; i++) if (got[i] !== keep[i]) errs++;
        chk("R3 strobe ignored while pending", 32'(errs), 0);
        host_sel_n = 1'b0;
        wait_cyc(HALF);
        chk("R10 scan_ok low while selected", 32'(scan_ok), 0);
        capture(other);
        host_sel_n = 1'b1;
        wait_cyc(HALF);
        chk("R3 strobe ignored while selected", 32'(host_sdo), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(HALF);
        t_reset();
        t_read_clock_high(24'h5A3C96);
        t_read_clock_low(24'hC3_0F81);
        t_read_clock_high(24'hFFFFFF);
        t_abort(24'h9E1B27);
        t_ignored(24'h800001, 24'h7FFFFE);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule